// File: doc/BRIEF.md
# Load Queue with Store Ordering Check

This block holds the in-flight loads of an out-of-order core in a circular buffer. Loads enter at the tail in program order, each tagged with its sequence number. Each load's effective address is attached later by queue index, once the load has executed. Commit retires the oldest loads from the head. A squash trims the youngest loads back from the tail. The block also reports how many new memory operations may be dispatched, taking into account the free space of a neighbouring store queue.

When a store executes, the block checks whether any younger load has already read memory that the store is about to write. The store supplies the load-queue position it recorded when it was dispatched. Every load from that position up to the current tail, and with an address present, is compared with the store address at 256-byte granularity. The hit nearest to the store's position is latched as the violator and a fault pulse is raised. The violator stays latched until the consumer reads it, and the read clears it. A single blocked-load flag is also kept, which a squash older than the blocked load releases.

Top module: `lq_order_queue`

## Requirements
- R1: With DEPTH slots, the queue holds at most DEPTH-1 loads and `lq_full` is 1 exactly when it holds DEPTH-1. An allocation while full is ignored.
- R2: An accepted allocation writes the entry at the tail, and `alloc_lq_idx` always shows that tail index. The tail then advances modulo DEPTH and `lq_count` rises by one.
- R3: `alloc_sq_tag` is all ones when `sq_empty_in` is 1. Otherwise it is `{1'b0, sq_tail_in}`.
- R4: `free_slots` equals min(DEPTH - `lq_count`, `sq_free_in`) - 1. This relies on `sq_free_in` being at least 1.
- R5: A commit removes loads from the head, one after another, for as long as the head load's sequence number is less than or equal to `commit_seq`. It stops at the first younger load.
- R6: A squash removes loads from the tail backward for as long as their sequence number is greater than `squash_seq`, and pulls the tail back. In the same cycle, a squash overrides any allocation or commit.
- R7: A store check covers positions from `st_lq_idx` up to, but not including, the tail, wrapping modulo DEPTH. A load matches when bits [ADDR_W-1:8] of its address equal those of `st_addr`. On a match, `st_fault` pulses in the same cycle, and from the next cycle the first match (nearest `st_lq_idx`) is shown on `viol_idx` and `viol_seq` with `viol_valid` high.
- R8: While `viol_valid` is 1, store checks are ignored: no fault, and the latched violator does not change.
- R9: Asserting `viol_rd` while `viol_valid` is 1 clears `viol_valid` from the next cycle.
- R10: A store check with no match raises no fault and leaves `viol_valid` at 0.
- R11: `blk_set` raises `load_blocked` and records `blk_seq`. A squash clears it only when `squash_seq` is less than the recorded number.
- R12: Allocation marks a load's address as absent and writeback marks it present. A load whose address is absent never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a load this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| sq_tail_in | input | SQ_IDX_W | Current store-queue tail |
| sq_empty_in | input | 1 | Store queue holds no stores |
| alloc_lq_idx | output | IDX_W | Index the next load will take (tail) |
| alloc_sq_tag | output | SQ_IDX_W+1 | Store-queue snapshot for the new load |
| lq_full | output | 1 | No slot free |
| sq_free_in | input | SQ_CNT_W | Free store-queue slots |
| free_slots | output | FREE_W | Dispatchable memory operations |
| lq_count | output | CNT_W | Loads held |
| lq_head | output | IDX_W | Index of the oldest load |
| wb_valid | input | 1 | Address writeback strobe |
| wb_idx | input | IDX_W | Slot that receives the address |
| wb_addr | input | ADDR_W | Effective address |
| st_valid | input | 1 | Store check request |
| st_addr | input | ADDR_W | Store effective address |
| st_lq_idx | input | IDX_W | Load position recorded by the store |
| st_fault | output | 1 | Ordering violation found this cycle |
| viol_valid | output | 1 | A violator is latched |
| viol_idx | output | IDX_W | Slot of the latched violator |
| viol_seq | output | SEQ_W | Sequence number of the latched violator |
| viol_rd | input | 1 | Read and clear the violator |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Loads younger than this are removed |
| blk_set | input | 1 | Record a blocked load |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| load_blocked | output | 1 | A blocked load is pending |

## Verification
The assertions rely on a well-behaved environment. Sequence numbers must rise with program order and never wrap. `wb_idx` must name an occupied slot. `st_lq_idx` must lie between the head and the tail. `sq_free_in` must be at least 1. The stimulus keeps to these limits by running a small reference ring alongside the block. Every writeback index and store position is taken from that ring's occupied range, and sequence numbers are issued in increasing order.

// File: rtl/lq_order_pkg.sv
package lq_order_pkg;
  // direction of a head/tail run over the ring
  typedef enum logic {WALK_FWD = 1'b0, WALK_BWD = 1'b1} lq_walk_e;

  localparam int unsigned LQ_DEPTH_DEF   = 8;
  localparam int unsigned LQ_SEQ_W_DEF   = 8;
  localparam int unsigned LQ_ADDR_W_DEF  = 16;
  localparam int unsigned LQ_GRAN_DEF    = 8;
  localparam int unsigned LQ_SQ_DEPTH_DEF = 8;
endpackage

// File: rtl/lq_edge_walk.sv
// Counts the run of entries at one end of the ring that satisfy the
// retire condition: forward from the head (seq <= thr) or backward
// from the tail (seq > thr). Stops at the first entry that fails.
module lq_edge_walk
  import lq_order_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned SEQ_W = 8,
  parameter lq_walk_e    DIR   = WALK_FWD,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0]            edge_idx,
  input  logic [CNT_W-1:0]            occ,
  input  logic [DEPTH-1:0][SEQ_W-1:0] seq_vec,
  input  logic [SEQ_W-1:0]            thr,
  output logic [CNT_W-1:0]            run_len,
  output logic [DEPTH-1:0]            run_mask
);
  logic             going;
  logic [IDX_W-1:0] pos;
  logic             cond;

  always_comb begin
    going    = 1'b1;
    run_len  = '0;
    run_mask = '0;
    pos      = '0;
    cond     = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (DIR == WALK_FWD) begin
        pos  = edge_idx + IDX_W'(k);
        cond = (seq_vec[pos] <= thr);
      end else begin
        pos  = edge_idx - IDX_W'(k + 1);
        cond = (seq_vec[pos] > thr);
      end
      if (going && (CNT_W'(k) < occ) && cond) begin
        run_len       = run_len + CNT_W'(1);
        run_mask[pos] = 1'b1;
      end else begin
        going = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lq_order_scan.sv
// Window mask from start to tail (exclusive, wrapping), granule compare,
// then pick the match nearest the start position.
module lq_order_scan #(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned GRAN_SHIFT = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned TAG_W = ADDR_W - GRAN_SHIFT
) (
  input  logic [IDX_W-1:0]             start_idx,
  input  logic [IDX_W-1:0]             tail_idx,
  input  logic [DEPTH-1:0]             vld_vec,
  input  logic [DEPTH-1:0]             av_vec,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addr_vec,
  input  logic [ADDR_W-1:0]            st_addr,
  output logic                         hit,
  output logic [IDX_W-1:0]             hit_idx
);
  logic [DEPTH-1:0] in_win;
  logic [DEPTH-1:0] match;
  logic [TAG_W-1:0] st_tag;
  logic             no_wrap;

  assign st_tag  = st_addr[ADDR_W-1:GRAN_SHIFT];
  assign no_wrap = (start_idx <= tail_idx);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic ge_start, lt_tail;
    assign ge_start  = (IDX_W'(i) >= start_idx);
    assign lt_tail   = (IDX_W'(i) <  tail_idx);
    assign in_win[i] = no_wrap ? (ge_start && lt_tail) : (ge_start || lt_tail);
    assign match[i]  = in_win[i] && vld_vec[i] && av_vec[i] &&
                       (addr_vec[i][ADDR_W-1:GRAN_SHIFT] == st_tag);
  end

  logic [IDX_W-1:0] pos;
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    pos     = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = start_idx + IDX_W'(k);
      if (!hit && match[pos]) begin
        hit     = 1'b1;
        hit_idx = pos;
      end
    end
  end
endmodule

// File: rtl/lq_order_queue.sv
module lq_order_queue
  import lq_order_pkg::*;
#(
  parameter int unsigned DEPTH      = LQ_DEPTH_DEF,
  parameter int unsigned SEQ_W      = LQ_SEQ_W_DEF,
  parameter int unsigned ADDR_W     = LQ_ADDR_W_DEF,
  parameter int unsigned GRAN_SHIFT = LQ_GRAN_DEF,
  parameter int unsigned SQ_DEPTH   = LQ_SQ_DEPTH_DEF,
  localparam int unsigned IDX_W    = $clog2(DEPTH),
  localparam int unsigned CNT_W    = IDX_W + 1,
  localparam int unsigned SQ_IDX_W = $clog2(SQ_DEPTH),
  localparam int unsigned SQ_CNT_W = $clog2(SQ_DEPTH + 1),
  localparam int unsigned FREE_W   = (CNT_W > SQ_CNT_W) ? CNT_W : SQ_CNT_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic [SEQ_W-1:0]     alloc_seq,
  input  logic [SQ_IDX_W-1:0]  sq_tail_in,
  input  logic                 sq_empty_in,
  output logic [IDX_W-1:0]     alloc_lq_idx,
  output logic [SQ_IDX_W:0]    alloc_sq_tag,
  output logic                 lq_full,
  input  logic [SQ_CNT_W-1:0]  sq_free_in,
  output logic [FREE_W-1:0]    free_slots,
  output logic [CNT_W-1:0]     lq_count,
  output logic [IDX_W-1:0]     lq_head,
  input  logic                 wb_valid,
  input  logic [IDX_W-1:0]     wb_idx,
  input  logic [ADDR_W-1:0]    wb_addr,
  input  logic                 st_valid,
  input  logic [ADDR_W-1:0]    st_addr,
  input  logic [IDX_W-1:0]     st_lq_idx,
  output logic                 st_fault,
  output logic                 viol_valid,
  output logic [IDX_W-1:0]     viol_idx,
  output logic [SEQ_W-1:0]     viol_seq,
  input  logic                 viol_rd,
  input  logic                 commit_valid,
  input  logic [SEQ_W-1:0]     commit_seq,
  input  logic                 squash_valid,
  input  logic [SEQ_W-1:0]     squash_seq,
  input  logic                 blk_set,
  input  logic [SEQ_W-1:0]     blk_seq,
  output logic                 load_blocked
);
  // ---------------- state ----------------
  logic [IDX_W-1:0]             head_q, head_d;
  logic [IDX_W-1:0]             tail_q, tail_d;
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic [DEPTH-1:0]             vld_q, vld_d;
  logic [DEPTH-1:0]             av_q, av_d;
  logic [DEPTH-1:0][SEQ_W-1:0]  seq_q;
  logic [DEPTH-1:0][ADDR_W-1:0] addr_q;
  logic                         vv_q, vv_d;
  logic [IDX_W-1:0]             vidx_q, vidx_d;
  logic [SEQ_W-1:0]             vseq_q, vseq_d;
  logic                         blk_q, blk_d;
  logic [SEQ_W-1:0]             bseq_q, bseq_d;

  // ---------------- control ----------------
  logic             sq_go, cm_go, al_go, scan_go;
  logic [CNT_W-1:0] n_cm, n_sq;
  logic [DEPTH-1:0] m_cm, m_sq;
  logic             scan_hit;
  logic [IDX_W-1:0] scan_idx;

  assign lq_full  = (cnt_q == CNT_W'(DEPTH - 1));
  assign sq_go    = squash_valid;
  assign cm_go    = commit_valid && !squash_valid;
  assign al_go    = alloc_valid && !squash_valid && !lq_full;
  assign scan_go  = st_valid && !vv_q;

  lq_edge_walk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DIR(WALK_FWD)) u_commit_walk (
    .edge_idx (head_q),
    .occ      (cnt_q),
    .seq_vec  (seq_q),
    .thr      (commit_seq),
    .run_len  (n_cm),
    .run_mask (m_cm)
  );

  lq_edge_walk #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .DIR(WALK_BWD)) u_squash_walk (
    .edge_idx (tail_q),
    .occ      (cnt_q),
    .seq_vec  (seq_q),
    .thr      (squash_seq),
    .run_len  (n_sq),
    .run_mask (m_sq)
  );

  lq_order_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .GRAN_SHIFT(GRAN_SHIFT)) u_scan (
    .start_idx (st_lq_idx),
    .tail_idx  (tail_q),
    .vld_vec   (vld_q),
    .av_vec    (av_q),
    .addr_vec  (addr_q),
    .st_addr   (st_addr),
    .hit       (scan_hit),
    .hit_idx   (scan_idx)
  );

  // ---------------- outputs ----------------
  logic [FREE_W-1:0] lq_free, sq_free, min_free;
  assign lq_free  = FREE_W'(DEPTH) - FREE_W'(cnt_q);
  assign sq_free  = FREE_W'(sq_free_in);
  assign min_free = (lq_free < sq_free) ? lq_free : sq_free;
  assign free_slots = min_free - FREE_W'(1);

  assign alloc_lq_idx = tail_q;
  assign alloc_sq_tag = sq_empty_in ? '1 : {1'b0, sq_tail_in};
  assign lq_count     = cnt_q;
  assign lq_head      = head_q;
  assign st_fault     = scan_go && scan_hit;
  assign viol_valid   = vv_q;
  assign viol_idx     = vidx_q;
  assign viol_seq     = vseq_q;
  assign load_blocked = blk_q;

  // ---------------- next state ----------------
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    vld_d  = vld_q;
    av_d   = av_q;
    if (sq_go) begin
      tail_d = tail_q - IDX_W'(n_sq);
      cnt_d  = cnt_q - n_sq;
      vld_d  = vld_q & ~m_sq;
    end else begin
      if (cm_go) begin
        head_d = head_q + IDX_W'(n_cm);
        vld_d  = vld_d & ~m_cm;
      end
      cnt_d = cnt_q - (cm_go ? n_cm : '0) + (al_go ? CNT_W'(1) : '0);
      if (al_go) begin
        tail_d        = tail_q + IDX_W'(1);
        vld_d[tail_q] = 1'b1;
      end
    end
    if (wb_valid) av_d[wb_idx] = 1'b1;
    if (al_go)    av_d[tail_q] = 1'b0;
  end

  always_comb begin
    vv_d   = vv_q;
    vidx_d = vidx_q;
    vseq_d = vseq_q;
    if (st_fault) begin
      vv_d   = 1'b1;
      vidx_d = scan_idx;
      vseq_d = seq_q[scan_idx];
    end else if (viol_rd) begin
      vv_d = 1'b0;
    end
  end

  always_comb begin
    blk_d  = blk_q;
    bseq_d = bseq_q;
    if (blk_set) begin
      blk_d  = 1'b1;
      bseq_d = blk_seq;
    end else if (squash_valid && blk_q && (squash_seq < bseq_q)) begin
      blk_d = 1'b0;
    end
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      vld_q  <= '0;
      av_q   <= '0;
      vv_q   <= 1'b0;
      vidx_q <= '0;
      vseq_q <= '0;
      blk_q  <= 1'b0;
      bseq_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      av_q   <= av_d;
      vv_q   <= vv_d;
      vidx_q <= vidx_d;
      vseq_q <= vseq_d;
      blk_q  <= blk_d;
      bseq_q <= bseq_d;
    end
  end

  always_ff @(posedge clk) begin
    if (al_go)    seq_q[tail_q]  <= alloc_seq;
    if (wb_valid) addr_q[wb_idx] <= wb_addr;
  end

  // ---------------- assertions ----------------
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_full && alloc_valid && !commit_valid && !squash_valid) |=> $stable(tail_q));

  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH - 1));

  assert_ptr_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(IDX_W'(tail_q - head_q))));

  assert_squash_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && alloc_valid) |=> (cnt_q <= $past(cnt_q)));

  assert_fault_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_fault |=> (vv_q && (vidx_q == $past(scan_idx))));

  assert_hold_viol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vv_q && !viol_rd) |=> (vv_q && $stable(vidx_q) && $stable(vseq_q)));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vv_q && viol_rd) |=> !vv_q);

  assert_blk_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q && !squash_valid) |=> blk_q);
endmodule

// File: tb/lq_order_queue_test.sv
module lq_order_queue_test;
  localparam int D = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       alloc_valid, sq_empty_in, wb_valid, st_valid, viol_rd;
  logic       commit_valid, squash_valid, blk_set;
  logic [7:0] alloc_seq, commit_seq, squash_seq, blk_seq, viol_seq;
  logic [2:0] sq_tail_in, alloc_lq_idx, lq_head, wb_idx, st_lq_idx, viol_idx;
  logic [3:0] alloc_sq_tag, sq_free_in, free_slots, lq_count;
  logic [15:0] wb_addr, st_addr;
  logic       lq_full, st_fault, viol_valid, load_blocked;

  int tests = 0, fails = 0;

  // reference ring
  int m_head = 0, m_tail = 0, m_cnt = 0;
  int m_seq[D];
  int m_addr[D];
  bit m_av[D];
  bit m_vv = 0;
  int m_vidx = 0, m_vseq = 0;
  bit m_blk = 0;
  int m_bseq = 0;

  always #4 clk = ~clk;

  lq_order_queue uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .sq_tail_in(sq_tail_in),
    .sq_empty_in(sq_empty_in), .alloc_lq_idx(alloc_lq_idx), .alloc_sq_tag(alloc_sq_tag),
    .lq_full(lq_full), .sq_free_in(sq_free_in), .free_slots(free_slots),
    .lq_count(lq_count), .lq_head(lq_head),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_addr(wb_addr),
    .st_valid(st_valid), .st_addr(st_addr), .st_lq_idx(st_lq_idx), .st_fault(st_fault),
    .viol_valid(viol_valid), .viol_idx(viol_idx), .viol_seq(viol_seq), .viol_rd(viol_rd),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .blk_set(blk_set), .blk_seq(blk_seq), .load_blocked(load_blocked)
  );

  task automatic chk(string rq, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_valid = 0; wb_valid = 0; st_valid = 0; viol_rd = 0;
    commit_valid = 0; squash_valid = 0; blk_set = 0;
  endtask

  task automatic chk_state(string rq);
    chk({rq, " count"}, int'(lq_count), m_cnt);
    chk({rq, " tail"}, int'(alloc_lq_idx), m_tail);
    chk({rq, " head"}, int'(lq_head), m_head);
  endtask

  task automatic chk_free();
    for (int f = 1; f <= 8; f++) begin
      sq_free_in = 4'(f);
      #1;
      chk("R4 free slots", int'(free_slots), ((D - m_cnt) < f ? (D - m_cnt) : f) - 1);
    end
    sq_free_in = 4'd8;
  endtask

  task automatic do_alloc(int s, bit sqe, int sqt);
    alloc_valid = 1; alloc_seq = 8'(s); sq_empty_in = sqe; sq_tail_in = 3'(sqt);
    #1;
    chk("R2 alloc index", int'(alloc_lq_idx), m_tail);
    chk("R3 store tag", int'(alloc_sq_tag), sqe ? 15 : sqt);
    chk("R1 full flag", int'(lq_full), int'(m_cnt == D - 1));
    step();
    alloc_valid = 0;
    if (m_cnt < D - 1) begin
      m_seq[m_tail] = s; m_av[m_tail] = 0;
      m_tail = (m_tail + 1) % D; m_cnt++;
    end
    chk_state("R2 R1 after alloc");
  endtask

  task automatic do_wb(int idx, int a);
    wb_valid = 1; wb_idx = 3'(idx); wb_addr = 16'(a);
    step();
    wb_valid = 0;
    m_addr[idx] = a; m_av[idx] = 1;
  endtask

  task automatic do_commit(int s);
    commit_valid = 1; commit_seq = 8'(s);
    step();
    commit_valid = 0;
    while (m_cnt > 0 && m_seq[m_head] <= s) begin
      m_head = (m_head + 1) % D; m_cnt--;
    end
    chk_state("R5 commit");
  endtask

  task automatic do_squash(int s, bit with_others);
    squash_valid = 1; squash_seq = 8'(s);
    if (with_others) begin
      alloc_valid = 1; alloc_seq = 8'd200; sq_empty_in = 1;
      commit_valid = 1; commit_seq = 8'd250;
    end
    step();
    idle();
    while (m_cnt > 0 && m_seq[(m_tail + D - 1) % D] > s) begin
      m_tail = (m_tail + D - 1) % D; m_cnt--;
    end
    if (m_blk && s < m_bseq) m_blk = 0;
    chk_state("R6 squash");
    chk("R11 blocked after squash", int'(load_blocked), int'(m_blk));
  endtask

  task automatic do_store(int a, int st);
    bit ef = 0;
    int ei = 0;
    int pos = st;
    st_valid = 1; st_addr = 16'(a); st_lq_idx = 3'(st);
    #1;
    if (!m_vv) begin
      while (pos != m_tail) begin
        if (!ef && m_av[pos] && ((m_addr[pos] >> 8) == (a >> 8))) begin
          ef = 1; ei = pos;
        end
        pos = (pos + 1) % D;
      end
    end
    chk(m_vv ? "R8 no fault while latched" : (ef ? "R7 fault" : "R10 R12 no fault"),
        int'(st_fault), int'(ef));
    step();
    st_valid = 0;
    if (ef) begin m_vv = 1; m_vidx = ei; m_vseq = m_seq[ei]; end
    chk("R7 R8 violator valid", int'(viol_valid), int'(m_vv));
    if (m_vv) begin
      chk("R7 R8 violator index", int'(viol_idx), m_vidx);
      chk("R7 R8 violator seq", int'(viol_seq), m_vseq);
    end
  endtask

  task automatic do_read();
    viol_rd = 1;
    #1;
    chk("R9 read returns violator", int'(viol_valid), int'(m_vv));
    step();
    viol_rd = 0;
    m_vv = 0;
    chk("R9 cleared after read", int'(viol_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle();
    alloc_seq = 0; commit_seq = 0; squash_seq = 0; blk_seq = 0;
    sq_tail_in = 0; sq_empty_in = 1; sq_free_in = 4'd8;
    wb_idx = 0; wb_addr = 0; st_addr = 0; st_lq_idx = 0;
    for (int i = 0; i < D; i++) begin m_seq[i] = 0; m_addr[i] = 0; m_av[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk_state("R2 reset");
    chk("R1 reset full", int'(lq_full), 0);
    chk("R7 reset violator", int'(viol_valid), 0);
    chk("R11 reset blocked", int'(load_blocked), 0);
    chk_free();

    // fill to full, then one ignored allocation
    for (int k = 0; k < 7; k++) begin
      do_alloc(10 + k, k[0], k);
      if (k == 3) chk_free();
    end
    chk_free();
    do_alloc(17, 0, 2);

    // addresses: slots 2 and 4 share granule 3, slot 5 left absent
    do_wb(0, 16'h0020); do_wb(1, 16'h0120); do_wb(2, 16'h0310);
    do_wb(3, 16'h0320); do_wb(4, 16'h0355); do_wb(6, 16'h0620);

    do_store(16'h03ff, 1);   // R7 first match is slot 2
    do_store(16'h0000, 0);   // R8 ignored while latched
    do_read();
    do_store(16'h0350, 4);   // R7 slot 4
    do_read();
    do_store(16'h0500, 5);   // R12 slot 5 absent
    do_store(16'h0000, 3);   // R7 slot 0 outside window
    do_read();               // R10 stays clear

    // commit
    do_commit(12);
    do_commit(5);
    chk_free();

    // wrap allocation
    do_alloc(17, 0, 4); do_alloc(18, 1, 0); do_alloc(19, 0, 7);
    do_wb(0, 16'h0900); do_wb(7, 16'h0920);
    do_store(16'h09aa, 6);   // R7 wrapped window, slot 7 first
    do_read();
    do_store(16'h09aa, 0);   // R7 slot 0
    do_read();

    // blocked load and squash
    blk_set = 1; blk_seq = 8'd16;
    step();
    blk_set = 0; m_blk = 1; m_bseq = 16;
    chk("R11 blocked set", int'(load_blocked), 1);
    do_squash(18, 1);        // R6 alloc/commit overridden, R11 held
    do_squash(40, 0);        // R6 nothing younger
    do_squash(15, 0);        // R6 trims, R11 cleared
    do_squash(0, 0);         // R6 empty

    // R12 new allocation clears address
    do_alloc(50, 1, 0);
    do_store(16'h0320, (m_tail + D - 1) % D);
    do_wb((m_tail + D - 1) % D, 16'h0333);
    do_store(16'h0320, (m_tail + D - 1) % D);
    do_read();
    do_commit(255);

    // sweep every start position over a full queue in one granule
    for (int k = 0; k < 7; k++) begin
      int slot = m_tail;
      do_alloc(60 + k, 0, k);
      do_wb(slot, 16'h0a00 + k * 3);
    end
    for (int o = 0; o < D; o++) begin
      do_store(16'h0aff, (m_head + o) % D);
      if (m_vv) do_read();
    end
    do_squash(62, 0);
    do_commit(255);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule